// File: doc/BRIEF.md
# PHY-to-Link Status Serializer

This block delivers status from the physical layer to the link controller over a two-bit data path. While it sends, it drives the status code on the two control lines. Event flags are collected from the rest of the PHY as single-cycle pulses and kept pending until they are delivered. The four flags are arbitration-reset gap, subaction gap, bus reset, and state timeout or cable-power low. Register contents are offered to the block through a valid/ready stream. After self-identification, the PHY pulses a request that queues the physical-ID register, and the block sends it on its own. When something is pending and the shared interface is idle, the block shifts the status word out two bits per clock.

The short form carries only the four flags in two beats. The full form takes eight beats. It carries a 16-bit word made of the flags in bits 0-3, the register address in bits 4-7 and the register data in bits 8-15. An incoming packet (`rx_preempt`) can take the interface mid-transfer. The block then yields in that same cycle, keeps everything pending and retries from the first beat. At least one quiet cycle always separates two transfers.

The register stream obeys back-pressure: one request is held in a single slot. `rd_ready` is low while that slot is occupied, and the requester must hold `rd_addr` and `rd_data` stable while `rd_valid` is high and `rd_ready` is low. The slot is released only when a full transfer carrying it completes.

Top module: `phy_status_tx`

## Requirements
- R1: After reset, `sts_ctl` and `sts_dat` are 2'b00 and `rd_ready` is 1.
- R2: A transfer begins (first beat on the ports) only in the cycle after a clock edge at which `bus_idle` was 1 and a flag or a register was pending; with `bus_idle` low nothing is sent.
- R3: During every beat `sts_ctl` equals 2'b01; beat k carries word bit 2k on `sts_dat[0]` and bit 2k+1 on `sts_dat[1]`, starting with bits 0 and 1.
- R4: With no register pending the transfer is two beats carrying flag bits 0-3 only.
- R5: With a register pending the transfer is eight beats carrying {data[7:0], addr[3:0], flags[3:0]} as bits 15..0.
- R6: `rd_ready` is low while a register is held; a request is taken on an edge with `rd_valid` and `rd_ready` both high; the slot frees only after the full transfer carrying it completes, and requests are delivered in arrival order.
- R7: A `sid_done` pulse queues a full transfer with address `PHYID_ADDR` (default 0) and data `sid_phy_reg`; it takes the slot ahead of a stream request offered in the same cycle (`rd_ready` is low in that cycle).
- R8: If `rx_preempt` is high during a beat, `sts_ctl` is not 2'b01 in that cycle, the transfer ends, and it is later resent from beat 0.
- R9: Flags accumulate by OR and are cleared only by a completed transfer that carried them; flags raised after a transfer started are sent by a later transfer.
- R10: Between any two transfers there is at least one cycle with `sts_ctl` not 2'b01; with work pending and `bus_idle` high, the next transfer starts after exactly one such cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_idle | input | 1 | Shared PHY/link interface is idle |
| rx_preempt | input | 1 | Incoming packet takes the interface |
| ev_flags | input | 4 | Event pulses: bit0 arb-reset gap, bit1 subaction gap, bit2 bus reset, bit3 timeout/cable power |
| sid_done | input | 1 | Self-ID finished pulse; queue the physical-ID register |
| sid_phy_reg | input | 8 | Physical-ID register contents |
| rd_valid | input | 1 | Register result valid |
| rd_ready | output | 1 | Register slot can accept |
| rd_addr | input | 4 | Register address |
| rd_data | input | 8 | Register contents |
| sts_ctl | output | 2 | Control-line code, 2'b01 while sending status |
| sts_dat | output | 2 | Data lines 0 and 1 |

## Verification
On every cycle, the assertions check the following. A transfer starts only after an idle interface and always at beat 0. The short form never runs past its second beat. A preempted or finished transfer is followed by a quiet cycle. Pending flags never vanish without a completion, and a held register stays stable until it is released. Only the bench's scenarios can show the delivered bit order and word contents, the ordering between self-ID and stream requests, the resend after a preemption with the later flag merged in, and the exact one-cycle spacing of back-to-back transfers.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } sts_state_e;

  localparam logic [1:0] CTL_STATUS = 2'b01;
  localparam logic [1:0] CTL_QUIET  = 2'b00;
endpackage

// File: rtl/sts_flag_accum.sv
module sts_flag_accum #(
  parameter int FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] ev_i,
  input  logic              clr_i,
  input  logic [FLAG_W-1:0] clr_mask_i,
  output logic [FLAG_W-1:0] pend_o
);
  logic [FLAG_W-1:0] pend_q;
  logic [FLAG_W-1:0] keep_w;

  always_comb begin
    keep_w = clr_i ? (pend_q & ~clr_mask_i) : pend_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= keep_w | ev_i;
  end

  assign pend_o = pend_q;

  // R9: a pending flag survives every cycle without a completed transfer
  assert_flag_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((~pend_q & $past(pend_q)) == '0))
    else $error("pending flag lost without completion");
endmodule

// File: rtl/sts_reg_slot.sv
module sts_reg_slot #(
  parameter int              ADDR_W     = 4,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] PHYID_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              sid_req_i,
  input  logic [DATA_W-1:0] sid_data_i,
  input  logic              free_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q, sid_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              take_sid, take_rd;

  assign rd_ready_o = !full_q && !sid_pend_q && !sid_req_i;
  assign take_sid   = !full_q && sid_pend_q;
  assign take_rd    = rd_valid_i && rd_ready_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      full_q     <= 1'b0;
      sid_pend_q <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      if (take_sid) begin
        full_q     <= 1'b1;
        sid_pend_q <= sid_req_i;
        addr_q     <= PHYID_ADDR;
        data_q     <= sid_data_i;
      end else begin
        if (sid_req_i) sid_pend_q <= 1'b1;
        if (take_rd) begin
          full_q <= 1'b1;
          addr_q <= rd_addr_i;
          data_q <= rd_data_i;
        end else if (free_i) begin
          full_q <= 1'b0;
        end
      end
    end
  end

  assign full_o = full_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R6: a held register stays put until its transfer completes
  assert_slot_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !free_i) |=> (full_q && $stable(addr_q) && $stable(data_q)))
    else $error("held register changed before release");

  // R7: a queued self-ID request claims the free slot with the fixed address
  assert_sid_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_q && sid_pend_q) |=> (full_q && addr_q == PHYID_ADDR))
    else $error("self-ID register not loaded");
endmodule

// File: rtl/sts_shift_fsm.sv
module sts_shift_fsm
  import sts_pkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_idle_i,
  input  logic              preempt_i,
  input  logic [FLAG_W-1:0] pend_i,
  input  logic              reg_full_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_data_i,
  output logic              done_o,
  output logic              done_full_o,
  output logic [FLAG_W-1:0] sent_flags_o,
  output logic [1:0]        ctl_o,
  output logic [LANES-1:0]  dat_o
);
  localparam int WORD_W      = FLAG_W + ADDR_W + DATA_W;
  localparam int FULL_BEATS  = WORD_W / LANES;
  localparam int SHORT_BEATS = FLAG_W / LANES;
  localparam int BEAT_W      = $clog2(FULL_BEATS);
  localparam logic [BEAT_W-1:0] LAST_FULL  = BEAT_W'(FULL_BEATS - 1);
  localparam logic [BEAT_W-1:0] LAST_SHORT = BEAT_W'(SHORT_BEATS - 1);

  sts_state_e        state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic [BEAT_W-1:0] beat_q;
  logic              full_q;
  logic              sending, start, last_beat, live_beat;
  logic [LANES-1:0]  beat_bits [FULL_BEATS];

  for (genvar b = 0; b < FULL_BEATS; b++) begin : g_beat
    assign beat_bits[b] = word_q[b*LANES +: LANES];
  end

  assign sending   = (state_q == ST_SEND);
  assign start     = !sending && bus_idle_i && ((|pend_i) || reg_full_i);
  assign last_beat = beat_q == (full_q ? LAST_FULL : LAST_SHORT);
  assign live_beat = sending && !preempt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_GAP: state_d = start ? ST_SEND : ST_IDLE;
      ST_SEND:         if (preempt_i || last_beat) state_d = ST_GAP;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      beat_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        beat_q <= '0;
        full_q <= reg_full_i;
        word_q <= reg_full_i ? {reg_data_i, reg_addr_i, pend_i}
                             : {{(DATA_W+ADDR_W){1'b0}}, pend_i};
      end else if (live_beat && !last_beat) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign done_o       = live_beat && last_beat;
  assign done_full_o  = done_o && full_q;
  assign sent_flags_o = word_q[FLAG_W-1:0];
  assign ctl_o        = live_beat ? CTL_STATUS : CTL_QUIET;
  assign dat_o        = live_beat ? beat_bits[beat_q] : '0;

  // R2: sending only ever follows an idle interface
  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sending) |-> $past(bus_idle_i))
    else $error("transfer began while interface busy");

  // R3: every transfer opens with the lowest bit pair
  assert_first_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sending) |-> (beat_q == '0))
    else $error("transfer did not begin at beat 0");

  // R4: the flag-only form never goes past its last beat
  assert_short_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending && !full_q) |-> (beat_q <= LAST_SHORT))
    else $error("short form overran");

  // R8: a preempted beat ends the transfer
  assert_abort_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending && preempt_i) |=> !sending)
    else $error("transfer continued after preemption");

  // R10: a quiet cycle follows every finished or aborted transfer
  assert_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending && (preempt_i || last_beat)) |=> !sending)
    else $error("no quiet cycle between transfers");
endmodule

// File: rtl/phy_status_tx.sv
module phy_status_tx #(
  parameter int                FLAG_W     = 4,
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter int                LANES      = 2,
  parameter logic [ADDR_W-1:0] PHYID_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_idle,
  input  logic              rx_preempt,
  input  logic [FLAG_W-1:0] ev_flags,
  input  logic              sid_done,
  input  logic [DATA_W-1:0] sid_phy_reg,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [1:0]        sts_ctl,
  output logic [LANES-1:0]  sts_dat
);
  logic [FLAG_W-1:0] pend, sent_flags;
  logic              done, done_full, slot_full;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;

  sts_flag_accum #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev_flags),
    .clr_i(done), .clr_mask_i(sent_flags), .pend_o(pend)
  );

  sts_reg_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHYID_ADDR(PHYID_ADDR)) u_slot (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready),
    .rd_addr_i(rd_addr), .rd_data_i(rd_data),
    .sid_req_i(sid_done), .sid_data_i(sid_phy_reg),
    .free_i(done_full), .full_o(slot_full),
    .addr_o(slot_addr), .data_o(slot_data)
  );

  sts_shift_fsm #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_fsm (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_idle_i(bus_idle), .preempt_i(rx_preempt),
    .pend_i(pend), .reg_full_i(slot_full),
    .reg_addr_i(slot_addr), .reg_data_i(slot_data),
    .done_o(done), .done_full_o(done_full), .sent_flags_o(sent_flags),
    .ctl_o(sts_ctl), .dat_o(sts_dat)
  );

  // R8: the status code is never on the control lines while a packet arrives
  assert_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_preempt |-> (sts_ctl != 2'b01))
    else $error("status driven during preemption");
endmodule

// File: tb/test_phy_status_tx.sv
module test_phy_status_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_idle = 1'b0, rx_preempt = 1'b0;
  logic [3:0] ev_flags = '0;
  logic       sid_done = 1'b0;
  logic [7:0] sid_phy_reg = '0;
  logic       rd_valid = 1'b0;
  logic       rd_ready;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data = '0;
  logic [1:0] sts_ctl, sts_dat;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  phy_status_tx i_phy_status_tx (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .rx_preempt(rx_preempt),
    .ev_flags(ev_flags), .sid_done(sid_done), .sid_phy_reg(sid_phy_reg),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .sts_ctl(sts_ctl), .sts_dat(sts_dat)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<40000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] exp_word(logic full, logic [3:0] f, logic [3:0] a, logic [7:0] d);
    return full ? {d, a, f} : {8'h00, 4'h0, f};
  endfunction

  function automatic int exp_beats(logic full);
    return full ? 8 : 2;
  endfunction

  task automatic grab(output logic [15:0] w, output int nb);
    int waited = 0;
    w = '0;
    nb = 0;
    while (sts_ctl != 2'b01 && waited < 40) begin tick(); waited++; end
    while (sts_ctl == 2'b01 && nb < 8) begin
      w[nb*2 +: 2] = sts_dat;
      nb++;
      tick();
    end
  endtask

  task automatic push_rd(logic [3:0] a, logic [7:0] d);
    rd_valid = 1'b1; rd_addr = a; rd_data = d;
    while (!rd_ready) tick();
    tick();
    rd_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] w;
    int nb;
    void'($urandom(32'd1394));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ctl", sts_ctl, 2'b00);
    chk("R1 dat", sts_dat, 2'b00);
    chk("R1 ready", rd_ready, 1'b1);

    // R2: nothing leaves while busy; first beat one edge after idle
    ev_flags = 4'b0101; tick(); ev_flags = 4'b0000;
    tick(); tick();
    chk("R2 busy hold", sts_ctl, 2'b00);
    bus_idle = 1'b1; tick();
    chk("R2 start", sts_ctl, 2'b01);
    chk("R3 beat0", sts_dat, 2'b01);
    tick();
    chk("R3 beat1", sts_dat, 2'b01);
    tick();
    chk("R4 short len", sts_ctl, 2'b00);
    tick(); tick();
    chk("R9 cleared", sts_ctl, 2'b00);

    // R5/R6: full form with back-pressure and ordering
    bus_idle = 1'b0;
    push_rd(4'h5, 8'hA5);
    chk("R6 ready low", rd_ready, 1'b0);
    rd_valid = 1'b1; rd_addr = 4'h9; rd_data = 8'h3C;
    tick(); tick();
    chk("R6 still low", rd_ready, 1'b0);
    bus_idle = 1'b1;
    grab(w, nb);
    chk("R5 word1", w, exp_word(1'b1, 4'h0, 4'h5, 8'hA5));
    chk("R5 beats1", nb, exp_beats(1'b1));
    while (!rd_ready) tick();
    tick();
    rd_valid = 1'b0;
    grab(w, nb);
    chk("R6 order word2", w, exp_word(1'b1, 4'h0, 4'h9, 8'h3C));

    // R7: self-ID wins over a same-cycle stream request
    bus_idle = 1'b0;
    tick();
    sid_done = 1'b1; sid_phy_reg = 8'h5A;
    rd_valid = 1'b1; rd_addr = 4'h7; rd_data = 8'h99;
    #1;
    chk("R7 ready low", rd_ready, 1'b0);
    tick();
    sid_done = 1'b0;
    bus_idle = 1'b1;
    grab(w, nb);
    chk("R7 sid word", w, exp_word(1'b1, 4'h0, 4'h0, 8'h5A));
    while (!rd_ready) tick();
    tick();
    rd_valid = 1'b0;
    grab(w, nb);
    chk("R7 then stream", w, exp_word(1'b1, 4'h0, 4'h7, 8'h99));

    // R8: preemption mid-transfer, resend with a merged later flag
    tick();
    ev_flags = 4'b1000; tick(); ev_flags = 4'b0000;
    while (sts_ctl != 2'b01) tick();
    chk("R3 abort beat0", sts_dat, 2'b00);
    tick();
    rx_preempt = 1'b1; ev_flags = 4'b0001;
    #1;
    chk("R8 yield", sts_ctl, 2'b00);
    tick();
    rx_preempt = 1'b0; ev_flags = 4'b0000;
    grab(w, nb);
    chk("R8 resend", w, exp_word(1'b0, 4'b1001, 4'h0, 8'h00));
    chk("R9 resend len", nb, exp_beats(1'b0));

    // R10/R9: back-to-back transfers with a flag raised mid-transfer
    tick();
    ev_flags = 4'b0100; tick(); ev_flags = 4'b0000;
    while (sts_ctl != 2'b01) tick();
    ev_flags = 4'b0010; tick(); ev_flags = 4'b0000;
    chk("R3 beat1 bits", sts_dat, 2'b01);
    tick();
    chk("R10 gap", sts_ctl, 2'b00);
    tick();
    chk("R10 one gap", sts_ctl, 2'b01);
    grab(w, nb);
    chk("R9 later flag", w, exp_word(1'b0, 4'b0010, 4'h0, 8'h00));

    // random mix: accumulate while busy, then one transfer
    for (int it = 0; it < 40; it++) begin
      logic [3:0] acc = '0;
      logic       use_reg = $urandom_range(0, 1) == 1;
      logic [3:0] ra = 4'($urandom);
      logic [7:0] rdv = 8'($urandom);
      int npul = $urandom_range(1, 3);
      bus_idle = 1'b0;
      tick();
      for (int p = 0; p < npul; p++) begin
        logic [3:0] f = 4'($urandom_range(1, 15));
        ev_flags = f; acc |= f; tick(); ev_flags = '0;
      end
      if (use_reg) push_rd(ra, rdv);
      tick();
      chk("R2 rand busy", sts_ctl, 2'b00);
      bus_idle = 1'b1;
      grab(w, nb);
      chk(use_reg ? "R5 rand word" : "R4 rand word", w, exp_word(use_reg, acc, ra, rdv));
      chk("R9 rand len", nb, exp_beats(use_reg));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule